// File: doc/BRIEF.md
# March C+ Memory Test Engine

This block is a hardware sequencer that tests a single-port synchronous RAM with the March C+ algorithm. A pulse on `start_i` begins the test. The engine then drives the RAM port directly, one operation per clock. It writes the all-zero and all-one background words and reads every cell back, comparing each read against the word it expects. When the whole sequence has run, it raises `done_o` for one cycle and reports whether any read mismatched. For the first mismatch it also gives the cell address and the element index.

The sequence has six march elements, numbered 0 to 5:

| Element | Operations per cell | Address order |
|---|---|---|
| 0 | w0 | set by `ends_down_i` |
| 1 | r0, w1, r1 | ascending |
| 2 | r1, w0, r0 | ascending |
| 3 | r0, w1, r1 | descending |
| 4 | r1, w0, r0 | descending |
| 5 | r0 | set by `ends_down_i` |

Here "0" means the word with every bit clear and "1" the word with every bit set. The order of elements 0 and 5 is taken from `ends_down_i` when the start is accepted. By default `stop_on_fail_i` is low and the engine runs to completion after a failure. When it is high, the engine abandons the sequence at the first mismatch.

The controller has four states:

- IDLE waits for start. IDLE→RUN happens on `start_i`.
- RUN issues one RAM operation per cycle. It has three exits:
  - RUN→DRAIN after the last operation of element 5.
  - RUN→DONE on a mismatch while `stop_on_fail_i` is high.
  - RUN→RUN in every other cycle.
- DRAIN compares the final read. DRAIN→DONE is unconditional.
- DONE pulses the done flag. DONE→IDLE is unconditional.

Top module: `march_cplus_engine`

## Requirements
- R1: After reset, and whenever the engine is not busy, `busy_o`, `done_o`, `mem_we_o` and `mem_re_o` are low, and `fail_o` is low until a mismatch occurs.
- R2: A full run issues exactly 3584 operations. Elements follow the order 0..5 with the per-cell operations in the table above. A write drives 0000h for data 0 and FFFFh for data 1 on `mem_wdata_o`. A read has `mem_re_o` high and `mem_we_o` low.
- R3: All operations for one address finish before the address moves one step. Elements 1 and 2 run from address 0 to 255, and elements 3 and 4 run from 255 to 0. Elements 0 and 5 run descending when `ends_down_i` was high at start, and ascending otherwise.
- R4: Exactly one of `mem_we_o` and `mem_re_o` is high in each RUN cycle. `busy_o` is high from the cycle after start until the DONE cycle. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R5: Read data are taken the cycle after `mem_re_o` and compared with the expected word. On the first mismatch, `fail_o` is set, `fail_addr_o` holds that read's address, and `fail_elem_o` holds its element index (0..5). Later mismatches leave these unchanged until the next start.
- R6: With `stop_on_fail_i` high, the cycle in which a mismatch is compared issues no RAM operation, and the next cycle is DONE.
- R7: `start_i` has no effect while the engine is running: the operation sequence and count are unchanged.
- R8: An accepted start clears `fail_o`, `fail_addr_o` and `fail_elem_o`. A run with no mismatch ends with `fail_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a test; sampled only in IDLE |
| ends_down_i | input | 1 | 1: elements 0 and 5 run descending |
| stop_on_fail_i | input | 1 | 1: end the run at the first mismatch |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| fail_o | output | 1 | A mismatch has been seen |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_elem_o | output | 3 | Element index of the first mismatch |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_re_o | output | 1 | RAM read strobe |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid the cycle after `mem_re_o` |

## Verification
Detection in the last element is the hardest case to reach from the ports. A static fault present from the start is always caught in element 1, so a failure in element 5 never appears on its own. The bench therefore drives a behavioural RAM whose stuck-at fault it switches on only after its own operation counter has passed the last operation of element 4. That is the only way the element-5 index and its address can show up on the failure outputs. A second hard case is the stop path. There the bench predicts the exact number of operations issued before the abort, from the faulty cell's position in element 1.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } march_state_e;

    localparam int ELEM_W    = 3;
    localparam int NUM_ELEM  = 6;
    localparam int STEP_W    = 2;

    typedef logic [ELEM_W-1:0] elem_idx_t;
    typedef logic [STEP_W-1:0] step_idx_t;

    localparam elem_idx_t LAST_ELEM = elem_idx_t'(NUM_ELEM - 1);

    // Address order of an element: the two end elements follow the run option.
    function automatic logic elem_is_down(input elem_idx_t e, input logic ends_down);
        logic d;
        case (e)
            3'd0, 3'd5: d = ends_down;
            3'd3, 3'd4: d = 1'b1;
            default:    d = 1'b0;
        endcase
        return d;
    endfunction

    // Index of the last operation per cell within an element.
    function automatic step_idx_t elem_last_step(input elem_idx_t e);
        return (e == 3'd0 || e == LAST_ELEM) ? step_idx_t'(0) : step_idx_t'(2);
    endfunction

    function automatic logic op_is_write(input elem_idx_t e, input step_idx_t s);
        logic w;
        case (e)
            3'd0:                   w = 1'b1;
            3'd1, 3'd2, 3'd3, 3'd4: w = (s == step_idx_t'(1));
            default:                w = 1'b0;
        endcase
        return w;
    endfunction

    // Background bit written or expected by an operation.
    function automatic logic op_data(input elem_idx_t e, input step_idx_t s);
        logic b;
        case (e)
            3'd1, 3'd3: b = (s != step_idx_t'(0));
            3'd2, 3'd4: b = (s == step_idx_t'(0));
            default:    b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_down_i,
    input  logic              step_i,
    input  logic              down_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_down_i ? ADDR_MAX : '0;
        end else if (step_i) begin
            addr_q <= down_i ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = down_i ? (addr_q == '0) : (addr_q == ADDR_MAX);

endmodule

// File: rtl/march_resp_check.sv
module march_resp_check
    import march_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              rd_issue_i,
    input  logic              exp_bit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  elem_idx_t         elem_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              mismatch_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output elem_idx_t         fail_elem_o
);
    logic              pend_q;
    logic              exp_q;
    logic [ADDR_W-1:0] addr_q;
    elem_idx_t         elem_q;

    // Read stage: remember what was asked for, compare when data return.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            exp_q  <= 1'b0;
            addr_q <= '0;
            elem_q <= '0;
        end else begin
            pend_q <= rd_issue_i && !clear_i;
            exp_q  <= exp_bit_i;
            addr_q <= addr_i;
            elem_q <= elem_i;
        end
    end

    assign mismatch_o = pend_q && (rdata_i != {DATA_W{exp_q}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_o      <= 1'b0;
            fail_addr_o <= '0;
            fail_elem_o <= '0;
        end else if (clear_i) begin
            fail_o      <= 1'b0;
            fail_addr_o <= '0;
            fail_elem_o <= '0;
        end else if (mismatch_o && !fail_o) begin
            fail_o      <= 1'b1;
            fail_addr_o <= addr_q;
            fail_elem_o <= elem_q;
        end
    end

endmodule

// File: rtl/march_cplus_engine.sv
module march_cplus_engine
    import march_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ends_down_i,
    input  logic              stop_on_fail_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [ELEM_W-1:0] fail_elem_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    march_state_e state_q, state_d;
    elem_idx_t    elem_q, elem_d;
    step_idx_t    step_q, step_d;
    logic         ends_down_q, ends_down_d;

    logic              accept, issue, abort, mismatch;
    logic              op_we, op_bit, last_step, cur_down;
    logic              gen_load, gen_load_down, gen_step, addr_last;
    logic [ADDR_W-1:0] cur_addr;
    elem_idx_t         fail_elem;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign cur_down  = elem_is_down(elem_q, ends_down_q);
    assign last_step = (step_q == elem_last_step(elem_q));
    assign op_we     = op_is_write(elem_q, step_q);
    assign op_bit    = op_data(elem_q, step_q);
    assign abort     = mismatch && stop_on_fail_i;
    assign issue     = (state_q == ST_RUN) && !abort;

    march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (gen_load),
        .load_down_i (gen_load_down),
        .step_i      (gen_step),
        .down_i      (cur_down),
        .addr_o      (cur_addr),
        .last_o      (addr_last)
    );

    march_resp_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .rd_issue_i  (issue && !op_we),
        .exp_bit_i   (op_bit),
        .addr_i      (cur_addr),
        .elem_i      (elem_q),
        .rdata_i     (mem_rdata_i),
        .mismatch_o  (mismatch),
        .fail_o      (fail_o),
        .fail_addr_o (fail_addr_o),
        .fail_elem_o (fail_elem)
    );

    assign fail_elem_o = fail_elem;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            elem_q      <= '0;
            step_q      <= '0;
            ends_down_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            elem_q      <= elem_d;
            step_q      <= step_d;
            ends_down_q <= ends_down_d;
        end
    end

    // Next state and sequencing
    always_comb begin
        state_d       = state_q;
        elem_d        = elem_q;
        step_d        = step_q;
        ends_down_d   = ends_down_q;
        gen_load      = 1'b0;
        gen_load_down = 1'b0;
        gen_step      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d       = ST_RUN;
                    elem_d        = '0;
                    step_d        = '0;
                    ends_down_d   = ends_down_i;
                    gen_load      = 1'b1;
                    gen_load_down = elem_is_down('0, ends_down_i);
                end
            end
            ST_RUN: begin
                if (abort) begin
                    state_d = ST_DONE;
                end else if (!last_step) begin
                    step_d = step_q + 1'b1;
                end else begin
                    step_d = '0;
                    if (!addr_last) begin
                        gen_step = 1'b1;
                    end else if (elem_q == LAST_ELEM) begin
                        state_d = ST_DRAIN;
                    end else begin
                        elem_d        = elem_q + 1'b1;
                        gen_load      = 1'b1;
                        gen_load_down = elem_is_down(elem_q + 1'b1, ends_down_q);
                    end
                end
            end
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q == ST_RUN) || (state_q == ST_DRAIN);
        done_o      = (state_q == ST_DONE);
        mem_addr_o  = cur_addr;
        mem_we_o    = issue && op_we;
        mem_re_o    = issue && !op_we;
        mem_wdata_o = {DATA_W{op_bit}};
    end

endmodule

// File: rtl/march_cplus_chk.sv
module march_cplus_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_on_fail_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o,
    input logic [ADDR_W-1:0] fail_addr_o,
    input logic [2:0]        fail_elem_o,
    input logic              mem_re_o,
    input logic              mem_we_o,
    input logic [DATA_W-1:0] mem_wdata_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_we_o && !mem_re_o));

    // R2
    pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1));

    // R4
    single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !mem_re_o);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !(start_i && !busy_o && !done_o))
        |=> (fail_o && $stable(fail_addr_o) && $stable(fail_elem_o)));

    // R6
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fail_o) && $past(stop_on_fail_i)) |-> done_o);

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind march_cplus_engine march_cplus_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stop_on_fail_i (stop_on_fail_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .fail_o         (fail_o),
    .fail_addr_o    (fail_addr_o),
    .fail_elem_o    (fail_elem_o),
    .mem_re_o       (mem_re_o),
    .mem_we_o       (mem_we_o),
    .mem_wdata_o    (mem_wdata_o)
);

// File: tb/tb_march_cplus_engine.sv
module tb_march_cplus_engine;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int TOTAL_OPS = 14 * DEPTH;
    localparam int E5_START  = 13 * DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              ends_down = 1'b0;
    logic              stop_on_fail = 1'b0;
    logic              busy, done, fail;
    logic [ADDR_W-1:0] fail_addr;
    logic [2:0]        fail_elem;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_re, mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int op_count = 0;
    int seq_err = 0;

    logic [DATA_W-1:0] ram [DEPTH];
    bit fault_on = 1'b0;
    bit fault_late = 1'b0;
    bit fault_pol = 1'b0;
    int fault_addr = 0;
    int fault_bit = 0;

    always #5 clk = ~clk;

    march_cplus_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ends_down_i(ends_down),
        .stop_on_fail_i(stop_on_fail), .busy_o(busy), .done_o(done), .fail_o(fail),
        .fail_addr_o(fail_addr), .fail_elem_o(fail_elem), .mem_addr_o(mem_addr),
        .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    // Behavioural RAM with one optional stuck-at bit on reads
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) begin
            logic [DATA_W-1:0] v;
            v = ram[mem_addr];
            if (fault_on && int'(mem_addr) == fault_addr) v[fault_bit] = fault_pol;
            mem_rdata <= v;
        end
    end

    // Expected operation k of a run, derived from the element table
    task automatic exp_op(input int k, input bit dn, output bit we, output bit b, output int a);
        int e, j, nops, ai, s;
        bit down;
        if (k < DEPTH) begin e = 0; j = k; nops = 1; end
        else if (k < E5_START) begin e = 1 + (k - DEPTH) / (3 * DEPTH); j = (k - DEPTH) % (3 * DEPTH); nops = 3; end
        else begin e = 5; j = k - E5_START; nops = 1; end
        ai = j / nops;
        s  = j % nops;
        down = (e == 0 || e == 5) ? dn : (e >= 3);
        a  = down ? (DEPTH - 1 - ai) : ai;
        we = (e == 0) || (e >= 1 && e <= 4 && s == 1);
        if (e == 1 || e == 3) b = (s != 0);
        else if (e == 2 || e == 4) b = (s == 0);
        else b = 1'b0;
    endtask

    // Sequence monitor (R2, R3)
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_re)) begin
            bit ew, eb;
            int ea;
            if (mem_we && mem_re) seq_err++;
            else if (op_count >= TOTAL_OPS) seq_err++;
            else begin
                exp_op(op_count, ends_down, ew, eb, ea);
                if (mem_we != ew || int'(mem_addr) != ea || (mem_we && mem_wdata != {DATA_W{eb}}))
                    seq_err++;
            end
            op_count++;
            if (fault_late && op_count == E5_START) fault_on = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_one(input bit dn, input bit stop, input bit fen, input bit fpol,
                           input int faddr, input int fbit, input bit late, input bit poke,
                           output int ops, output bit f, output int fa, output int fe);
        int guard;
        ends_down    = dn;
        stop_on_fail = stop;
        fault_pol    = fpol;
        fault_addr   = faddr;
        fault_bit    = fbit;
        fault_on     = fen && !late;
        fault_late   = fen && late;
        for (int i = 0; i < DEPTH; i++) ram[i] = 16'hC3C3 ^ DATA_W'(i);
        @(negedge clk);
        op_count = 0;
        seq_err  = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4 busy after start", int'(busy), 1);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke) start = (op_count >= 1000 && op_count < 1003);
        end
        start = 1'b0;
        chk(done == 1'b1, "R4 done reached", int'(done), 1);
        chk(busy == 1'b0, "R4 not busy at done", int'(busy), 0);
        f  = fail;
        fa = int'(fail_addr);
        fe = int'(fail_elem);
        @(negedge clk);
        chk(done == 1'b0, "R4 done one cycle", int'(done), 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R1 quiet after run", int'(mem_we | mem_re), 0);
        ops = op_count;
        chk(seq_err == 0, "R2 R3 operation sequence", seq_err, 0);
        fault_on   = 1'b0;
        fault_late = 1'b0;
    endtask

    initial begin
        int ops, fa, fe, a, b;
        bit f;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && fail == 0 && mem_we == 0 && mem_re == 0,
            "R1 reset outputs", int'({busy, done, fail, mem_we, mem_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Clean runs in both end orders
        for (int dn = 0; dn < 2; dn++) begin
            run_one(dn[0], 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, ops, f, fa, fe);
            chk(ops == TOTAL_OPS, "R2 op count clean", ops, TOTAL_OPS);
            chk(f == 1'b0, "R8 no fail clean", int'(f), 0);
        end

        // Stuck-at sweep: every static fault is first seen in element 1
        for (int dn = 0; dn < 2; dn++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int i = 0; i < 5; i++) begin
                    a = (i == 4) ? DEPTH - 1 : i * 60;
                    b = (i * 5 + pol * 3) % DATA_W;
                    run_one(dn[0], 1'b0, 1'b1, pol[0], a, b, 1'b0, 1'b0, ops, f, fa, fe);
                    chk(f == 1'b1, "R5 fail flagged", int'(f), 1);
                    chk(fa == a, "R5 first fail address", fa, a);
                    chk(fe == 1, "R5 first fail element", fe, 1);
                    chk(ops == TOTAL_OPS, "R5 runs to completion", ops, TOTAL_OPS);
                end
            end
        end

        // R8: next start clears the previous failure
        run_one(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, ops, f, fa, fe);
        chk(f == 1'b0 && fa == 0 && fe == 0, "R8 fail cleared", int'(f), 0);

        // R6: stop on stuck-at-1 at cell 50, caught by r0 of element 1
        run_one(1'b0, 1'b1, 1'b1, 1'b1, 50, 7, 1'b0, 1'b0, ops, f, fa, fe);
        chk(ops == DEPTH + 3 * 50 + 1, "R6 ops before abort sa1", ops, DEPTH + 151);
        chk(f == 1'b1 && fa == 50 && fe == 1, "R6 abort report sa1", fa, 50);

        // R6: stop on stuck-at-0 at cell 10, caught by final r1 of element 1
        run_one(1'b1, 1'b1, 1'b1, 1'b0, 10, 15, 1'b0, 1'b0, ops, f, fa, fe);
        chk(ops == DEPTH + 3 * 10 + 3, "R6 ops before abort sa0", ops, DEPTH + 33);
        chk(f == 1'b1 && fa == 10 && fe == 1, "R6 abort report sa0", fa, 10);

        // R5: fault appearing only in the last element, both end orders
        for (int dn = 0; dn < 2; dn++) begin
            run_one(dn[0], 1'b0, 1'b1, 1'b1, 100, 3, 1'b1, 1'b0, ops, f, fa, fe);
            chk(f == 1'b1, "R5 late fail flagged", int'(f), 1);
            chk(fa == 100, "R5 late fail address", fa, 100);
            chk(fe == 5, "R5 late fail element", fe, 5);
        end

        // R7: start pulsed mid-run is ignored
        run_one(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, ops, f, fa, fe);
        chk(ops == TOTAL_OPS, "R7 op count with mid-run start", ops, TOTAL_OPS);
        chk(f == 1'b0, "R7 no fail with mid-run start", int'(f), 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R7 no restart after run", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule